// File: doc/BRIEF.md
# SPI Register-File Slave Front End

This block lets an SPI host reach a 128-location byte-wide register space: timekeeping, alarm and control registers in the low addresses and a 96-byte scratch RAM from 0x20 up to 0x7F. Each transaction is framed by an active-high chip select. The first byte names a start address and a direction. Every later byte is written to, or read from, the next address in turn, so one transaction can move a whole register group. The register file behind the block is not part of it. The block only drives a strobe bus toward it: address, write data, write strobe, read strobe and returned read data.

The SPI pins are brought into the system clock domain through synchronizers, and the serial clock is edge-detected there. The serial clock must therefore stay in each phase for at least five system clock cycles. The register-side bus has no handshake and cannot apply back-pressure. A strobe is a one-cycle transfer that the register file must take, and on a read strobe it must present `reg_rdata` within that same cycle. The SPI side cannot stall either, so all flow control is set by the host's clock rate. The block also holds the write-protect gate. It keeps its own copy of the protect bit, taken from writes to the control register at 0x0F.

Top module: `spi_rf_slave`

## Requirements
- R1: The first byte after `spi_cs` rises is the command byte. Bit 7 = 1 makes the transaction a write and bit 7 = 0 makes it a read; bits 6:0 are the start address. In a write, every later complete byte gives one `reg_wr` pulse carrying that byte on `reg_wdata`. The command byte itself never writes.
- R2: SPI mode uses clock idle low and phase 1 with 8-bit words, MSB first. The slave updates `spi_miso` after each rising `spi_sclk` and samples `spi_mosi` on each falling `spi_sclk`.
- R3: Data bytes in one transaction go to, or come from, consecutive addresses starting at the command byte's address.
- R4: During a burst the address pointer wraps from 0x7F to 0x00.
- R5: Bit 6 of the last value written to 0x0F is the write-protect flag, and it is 0 after reset. While it is set, writes to any address other than 0x0F produce no `reg_wr`. Writes to 0x0F always pass and can clear the flag, and this takes effect for the very next byte of the same burst.
- R6: Addresses 0x12 to 0x1F are unmapped. Reads there return 0x00 on `spi_miso` and raise no `reg_rd`, and writes there raise no `reg_wr`.
- R7: When `spi_cs` drops, the bit counter resets and a partial byte is thrown away. The next transaction starts again with a command byte.
- R8: `spi_miso` is 0 within three clock cycles of `spi_cs` being low.
- R9: In a read transaction, a one-cycle `reg_rd` is issued for the next mapped address when the command byte completes and again when each data byte completes. That byte is loaded before the next byte's first output bit. N data bytes therefore give N+1 read strobes.
- R10: `reg_wr` and `reg_rd` are single-cycle pulses, are never high together, and are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 while deselected |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the `reg_rd` cycle |

## Verification
A falling serial-clock edge reaches the edge detector on the third clock edge after it. The matching `reg_wr` or `reg_rd` is high in the cycle that follows, and the read byte is loaded one clock later. A rising edge updates `spi_miso` after the same three edges. The bench host holds each serial-clock phase for eight clock cycles and samples `spi_miso` just before its falling edge, which is well after the slave updates it. The scoreboard matches write strobes in order, whatever cycle they arrive in, and counts read strobes only after deselect, once every pulse has landed.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic              sclk_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              done_q;
  logic              miso_q;
  logic              rise;
  logic              fall;

  // clock idle low, phase 1: drive on the leading edge, capture on the trailing one
  assign rise = cs_s &  sclk_s & ~sclk_q;
  assign fall = cs_s & ~sclk_s &  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      done_q <= 1'b0;
      if (!cs_s) begin
        cnt_q  <= '0;
        rx_q   <= '0;
        tx_q   <= '0;
        miso_q <= 1'b0;
      end else begin
        if (fall) begin
          rx_q <= {rx_q[BYTE_W-2:0], mosi_s};
          if (cnt_q == CNT_W'(BYTE_W - 1)) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (rise) miso_q <= tx_q[BYTE_W-1];
        if (load_en)   tx_q <= load_byte;
        else if (rise) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign miso      = miso_q;
endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned WP_ADDR  = 15,
  parameter int unsigned WP_BIT   = 6,
  parameter int unsigned HOLE_LO  = 18,
  parameter int unsigned HOLE_HI  = 31,
  parameter bit          WP_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic              load_en,
  output logic [BYTE_W-1:0] load_byte
);
  localparam int unsigned DIR_BIT = BYTE_W - 1;
  localparam logic [ADDR_W-1:0] WP_A = ADDR_W'(WP_ADDR);
  localparam logic [ADDR_W-1:0] H_LO = ADDR_W'(HOLE_LO);
  localparam logic [ADDR_W-1:0] H_HI = ADDR_W'(HOLE_HI);

  logic              first_q;
  logic              wr_mode_q;
  logic              wp_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] cur_addr;
  logic              in_hole;
  logic              wp_block;
  acc_e              acc;

  always_comb begin
    cur_addr = first_q ? rx_byte[ADDR_W-1:0] : ptr_q;
    acc      = ACC_NONE;
    if (byte_done) begin
      if (first_q) acc = rx_byte[DIR_BIT] ? ACC_NONE : ACC_READ;
      else         acc = wr_mode_q ? ACC_WRITE : ACC_READ;
    end
    in_hole  = (cur_addr >= H_LO) && (cur_addr <= H_HI);
    wp_block = wp_q && (cur_addr != WP_A);
  end

  assign reg_addr  = cur_addr;
  assign reg_wdata = rx_byte;
  assign reg_rd    = (acc == ACC_READ)  && !in_hole;
  assign reg_wr    = (acc == ACC_WRITE) && !in_hole && !wp_block;
  assign load_en   = (acc == ACC_READ);
  assign load_byte = in_hole ? '0 : reg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      wr_mode_q <= 1'b0;
      ptr_q     <= '0;
    end else if (!cs_s) begin
      first_q <= 1'b1;
    end else if (byte_done) begin
      first_q <= 1'b0;
      if (first_q) begin
        wr_mode_q <= rx_byte[DIR_BIT];
        ptr_q     <= rx_byte[DIR_BIT] ? rx_byte[ADDR_W-1:0]
                                      : rx_byte[ADDR_W-1:0] + 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wp_q <= WP_RESET;
    else if (reg_wr && cur_addr == WP_A) wp_q <= rx_byte[WP_BIT];
  end
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WP_ADDR     = 15,
  parameter int unsigned WP_BIT      = 6,
  parameter int unsigned HOLE_LO     = 18,
  parameter int unsigned HOLE_HI     = 31,
  parameter bit          WP_RESET    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata
);
  localparam int unsigned PIN_N = 3;

  logic [PIN_N-1:0]  pins_s;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              load_en;
  logic [BYTE_W-1:0] load_byte;

  spi_rf_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sclk, spi_cs, spi_mosi}),
    .q     (pins_s)
  );

  spi_rf_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .cs_s      (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .load_en   (load_en),
    .load_byte (load_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_rf_ctrl #(
    .ADDR_W   (ADDR_W),
    .WP_ADDR  (WP_ADDR),
    .WP_BIT   (WP_BIT),
    .HOLE_LO  (HOLE_LO),
    .HOLE_HI  (HOLE_HI),
    .WP_RESET (WP_RESET)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (pins_s[1]),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .load_en   (load_en),
    .load_byte (load_byte)
  );
endmodule

// File: rtl/spi_rf_slave_chk.sv
module spi_rf_slave_chk #(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned WP_ADDR = 15,
  parameter int unsigned WP_BIT  = 6,
  parameter int unsigned HOLE_LO = 18,
  parameter int unsigned HOLE_HI = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs,
  input logic              spi_miso,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              reg_wr,
  input logic              reg_rd
);
  logic wp_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_m <= 1'b0;
    else if (reg_wr && reg_addr == ADDR_W'(WP_ADDR)) wp_m <= reg_wdata[WP_BIT];
  end

  // R10
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R5
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wp_m) |-> (reg_addr == ADDR_W'(WP_ADDR)));

  // R6
  hole_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !((reg_addr >= ADDR_W'(HOLE_LO)) && (reg_addr <= ADDR_W'(HOLE_HI))));

  // R6
  hole_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !((reg_addr >= ADDR_W'(HOLE_LO)) && (reg_addr <= ADDR_W'(HOLE_HI))));

  // R8
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs && !$past(spi_cs) && !$past(spi_cs, 2) && !$past(spi_cs, 3)) |-> !spi_miso);
endmodule

bind spi_rf_slave spi_rf_slave_chk #(
  .ADDR_W  (ADDR_W),
  .WP_ADDR (WP_ADDR),
  .WP_BIT  (WP_BIT),
  .HOLE_LO (HOLE_LO),
  .HOLE_HI (HOLE_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_cs    (spi_cs),
  .spi_miso  (spi_miso),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd)
);

// File: tb/tb_spi_rf_slave.sv
`timescale 1ns/1ps
module tb_spi_rf_slave;
  localparam int H = 8;

  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs = 1'b0;
  logic       spi_mosi = 1'b0;
  logic       spi_miso;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_rdata;

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];
  wr_t        exp_q [$];
  bit         wp_m = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;
  int         rd_cnt = 0;
  int         wr_cnt = 0;
  int         hole_rd = 0;
  bit         prev_wr = 1'b0;
  bit         prev_rd = 1'b0;
  bit         ended = 1'b0;
  string      cur_req = "R1";

  always #4 clk = ~clk;

  spi_rf_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register file model behind the bus
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (rst_n && reg_wr) mem[reg_addr] <= reg_wdata;

  function automatic bit in_hole(input logic [6:0] a);
    return (a >= 7'h12) && (a <= 7'h1F);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, $sformatf("unexpected write @%0h", reg_addr), reg_wdata, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk({reg_addr, reg_wdata} == {e.a, e.d}, cur_req, "write addr/data",
              {reg_addr, reg_wdata}, {e.a, e.d});
        end
      end
      if (reg_rd) begin
        rd_cnt++;
        if (in_hole(reg_addr)) hole_rd++;
      end
      // R10 pulses last one cycle and never overlap
      if ((reg_wr && prev_wr) || (reg_rd && prev_rd) || (reg_wr && reg_rd))
        chk(1'b0, "R10", "strobe shape", {reg_wr, reg_rd}, 0);
      prev_wr = reg_wr;
      prev_rd = reg_rd;
    end
  end

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_sclk = 1'b1;
      spi_mosi = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic cs_on();
    spi_cs = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (H) @(negedge clk);
    spi_cs = 1'b0;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic wr_burst(input logic [6:0] a0, input int n, input logic [7:0] d0, input string req);
    logic [7:0] rx;
    logic [6:0] a;
    logic [7:0] d;
    cur_req = req;
    cs_on();
    spi_byte({1'b1, a0}, rx);
    for (int i = 0; i < n; i++) begin
      a = a0 + 7'(i);
      d = d0 + 8'(i);
      if (!in_hole(a) && (!wp_m || a == 7'h0F)) begin
        exp_q.push_back('{a: a, d: d});
        exp_mem[a] = d;
        if (a == 7'h0F) wp_m = d[6];
      end
      spi_byte(d, rx);
    end
    cs_off();
  endtask

  task automatic rd_burst(input logic [6:0] a0, input int n, input string req);
    logic [7:0] rx;
    logic [6:0] a;
    logic [7:0] e;
    cur_req = req;
    cs_on();
    spi_byte({1'b0, a0}, rx);
    for (int i = 0; i < n; i++) begin
      a = a0 + 7'(i);
      e = in_hole(a) ? 8'h00 : exp_mem[a];
      spi_byte(8'h00, rx);
      chk(rx == e, req, $sformatf("read @%0h", a), rx, e);
    end
    cs_off();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]     = in_hole(7'(i)) ? 8'hA5 : 8'(i * 3 + 1);
      exp_mem[i] = mem[i];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    int h0;
    int w0;
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    // R10 / R8 reset state
    chk(!reg_wr && !reg_rd, "R10", "strobes in reset", {reg_wr, reg_rd}, 0);
    chk(spi_miso == 1'b0, "R8", "miso in reset", spi_miso, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 write burst then read burst back
    wr_burst(7'h00, 3, 8'h10, "R1");
    rd_burst(7'h00, 3, "R3");
    // R2 MSB-first phase-1 reads from scratch RAM
    wr_burst(7'h20, 2, 8'h81, "R2");
    rd_burst(7'h20, 4, "R2");

    // R4 wrap 7F -> 00
    wr_burst(7'h7E, 3, 8'hC0, "R4");
    rd_burst(7'h7F, 2, "R4");

    // R9 read strobe count: N data bytes -> N+1 strobes
    r0 = rd_cnt;
    rd_burst(7'h40, 3, "R9");
    chk(rd_cnt - r0 == 4, "R9", "read strobes for 3-byte burst", rd_cnt - r0, 4);

    // R6 unmapped range
    w0 = wr_cnt;
    wr_burst(7'h12, 1, 8'h77, "R6");
    chk(wr_cnt == w0, "R6", "write strobes into hole", wr_cnt - w0, 0);
    r0 = rd_cnt;
    h0 = hole_rd;
    rd_burst(7'h11, 3, "R6");
    chk(rd_cnt - r0 == 1, "R6", "read strobes across hole", rd_cnt - r0, 1);
    chk(hole_rd == h0, "R6", "read strobes at hole addresses", hole_rd - h0, 0);

    // R5 write protect
    wr_burst(7'h0F, 1, 8'h40, "R5");
    w0 = wr_cnt;
    wr_burst(7'h05, 1, 8'h99, "R5");
    chk(wr_cnt == w0, "R5", "protected write strobes", wr_cnt - w0, 0);
    rd_burst(7'h05, 1, "R5");
    wr_burst(7'h0E, 3, 8'h00, "R5");
    rd_burst(7'h0E, 3, "R5");
    wr_burst(7'h05, 1, 8'h99, "R5");
    rd_burst(7'h05, 1, "R5");

    // R7 partial byte discarded
    cur_req = "R7";
    cs_on();
    for (int b = 0; b < 5; b++) begin
      spi_sclk = 1'b1; spi_mosi = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    cs_off();
    w0 = wr_cnt;
    wr_burst(7'h03, 1, 8'h3C, "R7");
    chk(wr_cnt - w0 == 1, "R7", "write after aborted byte", wr_cnt - w0, 1);
    rd_burst(7'h03, 1, "R7");

    // R8 miso cleared after deselect (last bit shifted out was 1)
    rd_burst(7'h7F, 1, "R8");
    chk(spi_miso == 1'b0, "R8", "miso after deselect", spi_miso, 0);
    junk = 8'h00;

    chk(exp_q.size() == 0, "R1", "expected writes left", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule